// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Process Tags

This block is a small translation buffer for a processor's memory pipeline. It turns a virtual page number into a physical page number. Every stored entry is compared against the request in the same cycle. Each entry carries the identifier of the address space it belongs to, so translations for several processes can stay resident across context switches. Each entry also carries three permission bits, and the lookup checks the requested kind of access against them. A registered response follows one cycle after each lookup. The response reports one of three outcomes: a translated hit, a miss, or a protection fault. A hit also returns the physical page and the full physical address.

After a miss, an external page-table walker installs the translation through the refill port. A refill first takes a free slot. When no slot is free, it takes the slot named by a rotating victim pointer. Software that switches address spaces can drop every entry at once, or only the entries of one process. The entry count is a parameter. Both 8 and 32 entries are intended, with a 13-bit page offset (8 KB pages).

Top module: `va_xlate_cache`

## Requirements
- R1: After reset no entry is valid, the response outputs are all 0, and the first lookup reports a miss.
- R2: A lookup matches an entry only when the entry is valid, its stored page number equals the request page number, and its stored process tag equals the request process tag. An entry installed under a different process tag never matches.
- R3: The response to a lookup presented in cycle t appears in cycle t+1 with `rsp_valid` high. In any cycle after a cycle with no lookup, `rsp_valid` is low.
- R4: On a translated hit, `rsp_ppn` is the stored physical page and `rsp_pa` is that page concatenated above the 13-bit request offset, which passes through unchanged.
- R5: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access code 0 is read, 1 is write, 2 is execute, and 3 is never permitted. A match whose access is not permitted reports `rsp_fault` instead of `rsp_hit`, with `rsp_ppn` and `rsp_pa` at 0.
- R6: Every response has exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` high. A lookup with no match reports `rsp_miss`.
- R7: A pulse on `fl_all` invalidates every entry, so every later lookup misses until a refill.
- R8: A pulse on `fl_one` invalidates only the entries whose process tag equals `fl_asid`. Entries of other processes keep hitting.
- R9: A refill with no existing match writes the lowest-numbered invalid slot, and the victim pointer does not move.
- R10: When every slot is valid, a refill replaces the slot named by the victim pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such replacement.
- R11: A refill whose page number and process tag equal those of a valid entry rewrites that entry in place with the new physical page and permissions.
- R12: A lookup in the same cycle as a refill or a flush is answered from the contents held before that cycle's update. A refill in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Process tag of the request |
| lk_off | input | OFF_W | Page offset, passed through |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rf_valid | input | 1 | Install an entry this cycle |
| rf_vpn | input | VPN_W | Virtual page of the new entry |
| rf_asid | input | ASID_W | Process tag of the new entry |
| rf_ppn | input | PPN_W | Physical page of the new entry |
| rf_perm | input | 3 | Permissions {execute, write, read} |
| fl_all | input | 1 | Invalidate every entry |
| fl_one | input | 1 | Invalidate entries tagged `fl_asid` |
| fl_asid | input | ASID_W | Process tag selected for the flush |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translated, permitted hit |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Match, but the access is not permitted |
| rsp_ppn | output | PPN_W | Physical page on a hit |
| rsp_pa | output | PPN_W+OFF_W | Physical address on a hit |

## Verification
The checker watches the properties that hold in every cycle. These are: at most one entry matches a request, a response follows each lookup exactly one cycle later, each response has exactly one outcome, the offset passes through on a hit, a fault carries no address, and a full flush leaves nothing valid. Some behaviour depends on history, and only the directed scenarios can show it. This includes replacement order once the buffer is full, the preference for free slots after a partial flush, in-place rewriting of an existing translation, isolation between process tags, and the answers given when a lookup collides with a refill or a flush in the same cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int PERM_W = 3;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Returns 1 when the permission set allows the access kind.
    function automatic logic perm_allows(logic [PERM_W-1:0] perm, acc_e acc);
        logic ok;
        case (acc)
            ACC_READ:  ok = perm[PERM_RD];
            ACC_WRITE: ok = perm[PERM_WR];
            ACC_EXEC:  ok = perm[PERM_EX];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int NUM_ENT = 8,
    parameter int VPN_W   = 30,
    parameter int ASID_W  = 8
) (
    input  logic [NUM_ENT-1:0]             vld,
    input  logic [NUM_ENT-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [NUM_ENT-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [NUM_ENT-1:0]             match
);

    // One comparator per slot, all working in parallel.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign match[g] = vld[g]
                       && (tag_vpn[g] == key_vpn)
                       && (tag_asid[g] == key_asid);
    end

endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int NUM_ENT = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_ENT-1:0] vld,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_rr
);

    // The lowest free slot wins. With no free slot, fall back to the pointer.
    always_comb begin
        slot   = rr_ptr;
        use_rr = 1'b1;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                slot   = IDX_W'(i);
                use_rr = 1'b0;
            end
        end
    end

endmodule

// File: rtl/va_xlate_cache.sv
module va_xlate_cache
    import xlate_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int VPN_W   = 30,
    parameter int ASID_W  = 8,
    parameter int PPN_W   = 21,
    parameter int OFF_W   = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VPN_W-1:0]         lk_vpn,
    input  logic [ASID_W-1:0]        lk_asid,
    input  logic [OFF_W-1:0]         lk_off,
    input  logic [1:0]               lk_acc,
    input  logic                     rf_valid,
    input  logic [VPN_W-1:0]         rf_vpn,
    input  logic [ASID_W-1:0]        rf_asid,
    input  logic [PPN_W-1:0]         rf_ppn,
    input  logic [PERM_W-1:0]        rf_perm,
    input  logic                     fl_all,
    input  logic                     fl_one,
    input  logic [ASID_W-1:0]        fl_asid,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic                     rsp_fault,
    output logic [PPN_W-1:0]         rsp_ppn,
    output logic [PPN_W+OFF_W-1:0]   rsp_pa
);

    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

    typedef struct packed {
        logic [NUM_ENT-1:0]             vld;
        logic [NUM_ENT-1:0][VPN_W-1:0]  vpn;
        logic [NUM_ENT-1:0][ASID_W-1:0] asid;
        logic [NUM_ENT-1:0][PPN_W-1:0]  ppn;
        logic [NUM_ENT-1:0][PERM_W-1:0] perm;
        logic [IDX_W-1:0]               rr;
        logic                           o_vld;
        logic                           o_hit;
        logic                           o_miss;
        logic                           o_flt;
        logic [PPN_W-1:0]               o_ppn;
        logic [PA_W-1:0]                o_pa;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_ENT-1:0] lk_match;
    logic [NUM_ENT-1:0] rf_match;
    logic [NUM_ENT-1:0] valid_q;
    logic [IDX_W-1:0]   vic_slot;
    logic               vic_use_rr;

    assign valid_q = s_q.vld;

    // Search port for lookups.
    xlate_cam #(
        .NUM_ENT (NUM_ENT),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_cam_lk (
        .vld      (s_q.vld),
        .tag_vpn  (s_q.vpn),
        .tag_asid (s_q.asid),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .match    (lk_match)
    );

    // Search port for refills: finds an existing copy to rewrite.
    xlate_cam #(
        .NUM_ENT (NUM_ENT),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_cam_rf (
        .vld      (s_q.vld),
        .tag_vpn  (s_q.vpn),
        .tag_asid (s_q.asid),
        .key_vpn  (rf_vpn),
        .key_asid (rf_asid),
        .match    (rf_match)
    );

    xlate_victim #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_victim (
        .vld    (s_q.vld),
        .rr_ptr (s_q.rr),
        .slot   (vic_slot),
        .use_rr (vic_use_rr)
    );

    logic [PPN_W-1:0]  hit_ppn;
    logic [PERM_W-1:0] hit_perm;
    logic              any_hit;
    logic              allowed;
    logic [IDX_W-1:0]  rf_idx;
    logic [IDX_W-1:0]  wr_idx;

    always_comb begin
        s_d = s_q;

        // Gather the single matching entry (an OR of one-hot selections).
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (lk_match[i]) begin
                hit_ppn  = hit_ppn  | s_q.ppn[i];
                hit_perm = hit_perm | s_q.perm[i];
            end
        end
        any_hit = |lk_match;
        allowed = perm_allows(hit_perm, acc_e'(lk_acc));

        // Response, taken from the contents before this cycle's update.
        s_d.o_vld  = lk_valid;
        s_d.o_hit  = lk_valid && any_hit && allowed;
        s_d.o_flt  = lk_valid && any_hit && !allowed;
        s_d.o_miss = lk_valid && !any_hit;
        s_d.o_ppn  = (lk_valid && any_hit && allowed) ? hit_ppn : '0;
        s_d.o_pa   = (lk_valid && any_hit && allowed) ? {hit_ppn, lk_off} : '0;

        // Slot of an existing copy of the refill translation.
        rf_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (rf_match[i]) begin
                rf_idx = IDX_W'(i);
            end
        end
        wr_idx = (|rf_match) ? rf_idx : vic_slot;

        // Contents update: a flush overrides a refill in the same cycle.
        if (fl_all) begin
            s_d.vld = '0;
        end else if (fl_one) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (s_q.asid[i] == fl_asid) begin
                    s_d.vld[i] = 1'b0;
                end
            end
        end else if (rf_valid) begin
            s_d.vld[wr_idx]  = 1'b1;
            s_d.vpn[wr_idx]  = rf_vpn;
            s_d.asid[wr_idx] = rf_asid;
            s_d.ppn[wr_idx]  = rf_ppn;
            s_d.perm[wr_idx] = rf_perm;
            if (!(|rf_match) && vic_use_rr) begin
                s_d.rr = (s_q.rr == LAST_IDX) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.o_vld;
    assign rsp_hit   = s_q.o_hit;
    assign rsp_miss  = s_q.o_miss;
    assign rsp_fault = s_q.o_flt;
    assign rsp_ppn   = s_q.o_ppn;
    assign rsp_pa    = s_q.o_pa;

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
    parameter int NUM_ENT = 8,
    parameter int PPN_W   = 21,
    parameter int OFF_W   = 13
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [OFF_W-1:0]       lk_off,
    input logic                   rf_valid,
    input logic                   fl_all,
    input logic                   fl_one,
    input logic [NUM_ENT-1:0]     lk_match,
    input logic [NUM_ENT-1:0]     valid_q,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic                   rsp_miss,
    input logic                   rsp_fault,
    input logic [PPN_W+OFF_W-1:0] rsp_pa
);

    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_no_spurious_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || (rsp_pa[OFF_W-1:0] == $past(lk_off))));

    p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pa == '0));

    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (valid_q == '0));

    p_flush_one_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_one && !fl_all) |=> ($countones(valid_q) <= $countones($past(valid_q))));

    p_refill_dropped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && (fl_all || fl_one)) |=> ($countones(valid_q) <= $countones($past(valid_q))));

endmodule

bind va_xlate_cache xlate_chk #(
    .NUM_ENT (NUM_ENT),
    .PPN_W   (PPN_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_off    (lk_off),
    .rf_valid  (rf_valid),
    .fl_all    (fl_all),
    .fl_one    (fl_one),
    .lk_match  (lk_match),
    .valid_q   (valid_q),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa)
);

// File: tb/test_va_xlate_cache.sv
module test_va_xlate_cache;

    localparam int NUM_ENT = 8;
    localparam int VPN_W   = 30;
    localparam int ASID_W  = 8;
    localparam int PPN_W   = 21;
    localparam int OFF_W   = 13;

    localparam int K_MISS  = 0;
    localparam int K_HIT   = 1;
    localparam int K_FAULT = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   lk_valid = 1'b0;
    logic [VPN_W-1:0]       lk_vpn = '0;
    logic [ASID_W-1:0]      lk_asid = '0;
    logic [OFF_W-1:0]       lk_off = '0;
    logic [1:0]             lk_acc = '0;
    logic                   rf_valid = 1'b0;
    logic [VPN_W-1:0]       rf_vpn = '0;
    logic [ASID_W-1:0]      rf_asid = '0;
    logic [PPN_W-1:0]       rf_ppn = '0;
    logic [2:0]             rf_perm = '0;
    logic                   fl_all = 1'b0;
    logic                   fl_one = 1'b0;
    logic [ASID_W-1:0]      fl_asid = '0;
    logic                   rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [PPN_W-1:0]       rsp_ppn;
    logic [PPN_W+OFF_W-1:0] rsp_pa;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    va_xlate_cache #(
        .NUM_ENT (NUM_ENT),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .PPN_W   (PPN_W),
        .OFF_W   (OFF_W)
    ) i_va_xlate_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_vpn    (lk_vpn),
        .lk_asid   (lk_asid),
        .lk_off    (lk_off),
        .lk_acc    (lk_acc),
        .rf_valid  (rf_valid),
        .rf_vpn    (rf_vpn),
        .rf_asid   (rf_asid),
        .rf_ppn    (rf_ppn),
        .rf_perm   (rf_perm),
        .fl_all    (fl_all),
        .fl_one    (fl_one),
        .fl_asid   (fl_asid),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_fault (rsp_fault),
        .rsp_ppn   (rsp_ppn),
        .rsp_pa    (rsp_pa)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Checks the response present at the current negedge.
    task automatic expect_rsp(input int kind, input logic [PPN_W-1:0] ppn,
                              input logic [OFF_W-1:0] off, input string req);
        logic [PPN_W+OFF_W-1:0] exp_pa;
        int act_kind;
        exp_pa = (kind == K_HIT) ? {ppn, off} : '0;
        act_kind = rsp_hit ? K_HIT : (rsp_fault ? K_FAULT : (rsp_miss ? K_MISS : -1));
        check(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
        check(act_kind == kind && (rsp_hit + rsp_miss + rsp_fault) == 1, req, "outcome",
              act_kind, kind);
        check(rsp_pa == exp_pa, req, "rsp_pa", rsp_pa, exp_pa);
        check(rsp_ppn == ((kind == K_HIT) ? ppn : '0), req, "rsp_ppn", rsp_ppn,
              (kind == K_HIT) ? ppn : 0);
    endtask

    task automatic drive_lookup(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                                input logic [OFF_W-1:0] off, input logic [1:0] acc);
        lk_valid = 1'b1;
        lk_vpn   = vpn;
        lk_asid  = asid;
        lk_off   = off;
        lk_acc   = acc;
    endtask

    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                          input logic [OFF_W-1:0] off, input logic [1:0] acc,
                          input int kind, input logic [PPN_W-1:0] ppn, input string req);
        drive_lookup(vpn, asid, off, acc);
        @(negedge clk);
        lk_valid = 1'b0;
        expect_rsp(kind, ppn, off, req);
    endtask

    task automatic drive_refill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                                input logic [PPN_W-1:0] ppn, input logic [2:0] perm);
        rf_valid = 1'b1;
        rf_vpn   = vpn;
        rf_asid  = asid;
        rf_ppn   = ppn;
        rf_perm  = perm;
    endtask

    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                          input logic [PPN_W-1:0] ppn, input logic [2:0] perm);
        drive_refill(vpn, asid, ppn, perm);
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic t_reset;
        check(rsp_valid == 0 && rsp_hit == 0 && rsp_miss == 0 && rsp_fault == 0,
              "R1", "outputs after reset", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
        check(rsp_pa == '0, "R1", "rsp_pa after reset", rsp_pa, 0);
        lookup(30'h5, 8'd1, 13'h0, 2'd0, K_MISS, '0, "R1");
        lookup(30'h0, 8'd0, 13'h0, 2'd0, K_MISS, '0, "R1");
    endtask

    task automatic t_basic;
        refill(30'h100, 8'd1, 21'h1AB, 3'b111);
        lookup(30'h100, 8'd1, 13'h1234, 2'd0, K_HIT, 21'h1AB, "R4");
        // R3: the cycle after a lookup-free cycle carries no response.
        @(negedge clk);
        check(rsp_valid == 1'b0, "R3", "rsp_valid idle", rsp_valid, 0);
        lookup(30'h100, 8'd1, 13'h1FFF, 2'd1, K_HIT, 21'h1AB, "R4");
        lookup(30'h101, 8'd1, 13'h0, 2'd0, K_MISS, '0, "R6");
    endtask

    task automatic t_asid;
        lookup(30'h100, 8'd2, 13'h10, 2'd0, K_MISS, '0, "R2");
        refill(30'h100, 8'd2, 21'h2CD, 3'b001);
        lookup(30'h100, 8'd2, 13'h10, 2'd0, K_HIT, 21'h2CD, "R2");
        lookup(30'h100, 8'd1, 13'h10, 2'd0, K_HIT, 21'h1AB, "R2");
    endtask

    task automatic t_perm;
        lookup(30'h100, 8'd2, 13'h7, 2'd1, K_FAULT, '0, "R5");
        lookup(30'h100, 8'd2, 13'h7, 2'd2, K_FAULT, '0, "R5");
        lookup(30'h100, 8'd1, 13'h7, 2'd3, K_FAULT, '0, "R5");
        lookup(30'h100, 8'd1, 13'h7, 2'd2, K_HIT, 21'h1AB, "R5");
    endtask

    task automatic t_overwrite;
        refill(30'h100, 8'd1, 21'h0EE, 3'b001);
        lookup(30'h100, 8'd1, 13'h3, 2'd1, K_FAULT, '0, "R11");
        lookup(30'h100, 8'd1, 13'h3, 2'd0, K_HIT, 21'h0EE, "R11");
    endtask

    task automatic t_fill_evict;
        // Slots 0 and 1 are in use: these six land in slots 2..7.
        for (int k = 0; k < NUM_ENT - 2; k++) begin
            refill(30'h200 + VPN_W'(k), 8'd3, 21'h3000 + PPN_W'(k), 3'b111);
        end
        lookup(30'h100, 8'd1, 13'h1, 2'd0, K_HIT, 21'h0EE, "R9");
        lookup(30'h100, 8'd2, 13'h1, 2'd0, K_HIT, 21'h2CD, "R9");
        for (int k = 0; k < NUM_ENT - 2; k++) begin
            lookup(30'h200 + VPN_W'(k), 8'd3, 13'h2, 2'd0, K_HIT, 21'h3000 + PPN_W'(k), "R9");
        end
        // Full: the pointer names slot 0, then slot 1.
        refill(30'h300, 8'd4, 21'h4000, 3'b111);
        refill(30'h301, 8'd3, 21'h4001, 3'b111);
        lookup(30'h100, 8'd1, 13'h1, 2'd0, K_MISS, '0, "R10");
        lookup(30'h100, 8'd2, 13'h1, 2'd0, K_MISS, '0, "R10");
        lookup(30'h300, 8'd4, 13'h1, 2'd0, K_HIT, 21'h4000, "R10");
        lookup(30'h301, 8'd3, 13'h1, 2'd0, K_HIT, 21'h4001, "R10");
        for (int k = 0; k < NUM_ENT - 2; k++) begin
            lookup(30'h200 + VPN_W'(k), 8'd3, 13'h2, 2'd0, K_HIT, 21'h3000 + PPN_W'(k), "R10");
        end
    endtask

    task automatic t_flush_one;
        fl_one  = 1'b1;
        fl_asid = 8'd3;
        @(negedge clk);
        fl_one = 1'b0;
        lookup(30'h300, 8'd4, 13'h5, 2'd0, K_HIT, 21'h4000, "R8");
        lookup(30'h301, 8'd3, 13'h5, 2'd0, K_MISS, '0, "R8");
        lookup(30'h203, 8'd3, 13'h5, 2'd0, K_MISS, '0, "R8");
        // Seven free slots are filled first; the asid-4 entry must survive (R9).
        for (int k = 0; k < NUM_ENT - 1; k++) begin
            refill(30'h600 + VPN_W'(k), 8'd5, 21'h6000 + PPN_W'(k), 3'b111);
        end
        lookup(30'h300, 8'd4, 13'h5, 2'd0, K_HIT, 21'h4000, "R9");
        for (int k = 0; k < NUM_ENT - 1; k++) begin
            lookup(30'h600 + VPN_W'(k), 8'd5, 13'h6, 2'd0, K_HIT, 21'h6000 + PPN_W'(k), "R9");
        end
    endtask

    task automatic t_flush_all;
        fl_all = 1'b1;
        @(negedge clk);
        fl_all = 1'b0;
        lookup(30'h300, 8'd4, 13'h5, 2'd0, K_MISS, '0, "R7");
        lookup(30'h600, 8'd5, 13'h5, 2'd0, K_MISS, '0, "R7");
        lookup(30'h606, 8'd5, 13'h5, 2'd0, K_MISS, '0, "R7");
    endtask

    task automatic t_same_cycle;
        // Lookup and refill together: the lookup sees the old contents.
        drive_refill(30'h400, 8'd6, 21'h0044, 3'b111);
        drive_lookup(30'h400, 8'd6, 13'hA, 2'd0);
        @(negedge clk);
        rf_valid = 1'b0;
        lk_valid = 1'b0;
        expect_rsp(K_MISS, '0, 13'hA, "R12");
        lookup(30'h400, 8'd6, 13'hA, 2'd0, K_HIT, 21'h0044, "R12");
        // Lookup and full flush together: the lookup still hits.
        fl_all = 1'b1;
        drive_lookup(30'h400, 8'd6, 13'hB, 2'd0);
        @(negedge clk);
        fl_all = 1'b0;
        lk_valid = 1'b0;
        expect_rsp(K_HIT, 21'h0044, 13'hB, "R12");
        lookup(30'h400, 8'd6, 13'hB, 2'd0, K_MISS, '0, "R12");
        // Refill with a per-process flush of another tag: the refill is dropped.
        fl_one  = 1'b1;
        fl_asid = 8'd9;
        drive_refill(30'h500, 8'd7, 21'h0055, 3'b111);
        @(negedge clk);
        fl_one   = 1'b0;
        rf_valid = 1'b0;
        lookup(30'h500, 8'd7, 13'hC, 2'd0, K_MISS, '0, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_asid();
        t_perm();
        t_overwrite();
        t_fill_evict();
        t_flush_one();
        t_flush_all();
        t_same_cycle();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule